// File: doc/BRIEF.md
# Warp Issue Scheduler

This block decides which warps in a throughput-oriented multiprocessor send an instruction down the execution pipes in each clock cycle. It keeps one context slot for each possible warp ID, 48 by default. Each warp holds 32 threads, so a full table covers 1536 threads. A slot is empty, ready, busy for a fixed number of cycles after an issue, or parked while it waits for a long-latency memory operation. Memory waits can last hundreds of cycles. The scheduler fills those cycles by issuing other warps, and it can select two different warps per cycle.

Two independent issue ports carry a valid flag and a warp ID. Each pipe answers in the same cycle with an accept, plus two flags: the accepted instruction is a long-latency memory access, or it is the warp's last instruction. A memory-completion input carries the warp ID whose access has returned. A launch input fills a free slot. The slot index is the warp ID, so a slot is free when no warp with that ID is resident.

Top module: `warp_issue_sched`

## Requirements
- R1: After a synchronous reset, no warp is resident, and both `iss0_vld` and `iss1_vld` are low.
- R2: A launch whose ID names a free slot makes that warp eligible in the following cycle. A launch that names an occupied slot leaves the slot's state unchanged.
- R3: When both ports are valid in a cycle, they carry different warp IDs.
- R4: A warp accepted in cycle t is not offered on either port in cycles t+1 to t+3. With no other hold, it is offered again in cycle t+4.
- R5: If exactly one warp is ready, only port 0 is valid. If no warp is ready, both ports are idle. Port 1 is never valid while port 0 is idle.
- R6: A port offers a warp only if the warp is resident, not waiting on memory, and has no busy cycles left.
- R7: An accept with `issN_mem` high parks the warp until `mem_done_vld` arrives with its ID. The warp is eligible in the cycle after that completion, provided its busy cycles have run out.
- R8: An accept with `issN_exit` high frees the slot (exit takes precedence over the memory flag). The warp is not offered again until the same ID is launched again.
- R9: Port 0 offers the first ready warp at or after a rotating pointer, in ascending ID order with wrap-around. Port 1 offers the next ready warp after port 0's warp. After any accept, the pointer moves to one past the highest-numbered port that accepted (port 1 over port 0).
- R10: A warp that is offered but not accepted keeps its state, and the pointer does not move. The offer is repeated in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_vld | input | 1 | Request to make a warp resident |
| launch_wid | input | 6 | Warp ID (slot) to launch |
| mem_done_vld | input | 1 | A memory access has completed |
| mem_done_wid | input | 6 | Warp whose access completed |
| iss0_vld | output | 1 | Port 0 offers a warp |
| iss0_wid | output | 6 | Warp ID on port 0 |
| iss0_acc | input | 1 | Pipe 0 takes the offered warp this cycle |
| iss0_mem | input | 1 | The accepted instruction on port 0 is a long-latency load or store |
| iss0_exit | input | 1 | The accepted instruction on port 0 ends the warp |
| iss1_vld | output | 1 | Port 1 offers a warp |
| iss1_wid | output | 6 | Warp ID on port 1 |
| iss1_acc | input | 1 | Pipe 1 takes the offered warp this cycle |
| iss1_mem | input | 1 | The accepted instruction on port 1 is a long-latency load or store |
| iss1_exit | input | 1 | The accepted instruction on port 1 ends the warp |

## Verification
The assertions assume that an accept, memory flag or exit flag only has meaning in a cycle where its port is valid. They also assume that a completion ID below the warp count may target any slot, including one that is not parked. The stimulus raises accept and its flags only in cycles where the bench expects an offer, and it never sets memory and exit together. Launch and completion IDs always stay below 48, and launches repeat an occupied ID on purpose to check that the slot's state is untouched.

// File: rtl/ws_pkg.sv
package ws_pkg;

    localparam int unsigned WS_NUM_WARPS   = 48;
    localparam int unsigned WS_BUSY_CYCLES = 4;

    // what an accepted issue does to a slot
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_PLAIN = 2'd1,
        ACT_MEM   = 2'd2,
        ACT_EXIT  = 2'd3
    } ws_act_e;

    typedef struct packed {
        logic resident;
        logic stalled;
    } ws_flags_t;

    function automatic ws_act_e ws_decode_act(input logic take,
                                              input logic mem,
                                              input logic fin);
        if (!take) return ACT_NONE;
        if (fin)   return ACT_EXIT;
        if (mem)   return ACT_MEM;
        return ACT_PLAIN;
    endfunction

endpackage

// File: rtl/ws_slot.sv
module ws_slot
    import ws_pkg::*;
#(
    parameter int unsigned BUSY = WS_BUSY_CYCLES,
    localparam int unsigned BW  = (BUSY > 1) ? $clog2(BUSY) : 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    launch_hit,
    input  logic    wake,
    input  ws_act_e act,
    output logic    ready,
    output logic    stalled
);

    ws_flags_t       flags_q;
    logic [BW-1:0]   busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            busy_q  <= '0;
        end else begin
            case (act)
                ACT_EXIT: begin
                    flags_q <= '0;
                    busy_q  <= '0;
                end
                ACT_MEM: begin
                    flags_q.stalled <= 1'b1;
                    busy_q          <= BW'(BUSY - 1);
                end
                ACT_PLAIN: begin
                    busy_q <= BW'(BUSY - 1);
                end
                default: begin
                    if (launch_hit && !flags_q.resident) begin
                        flags_q.resident <= 1'b1;
                        flags_q.stalled  <= 1'b0;
                        busy_q           <= '0;
                    end else begin
                        if (busy_q != '0) busy_q <= busy_q - 1'b1;
                        if (wake) flags_q.stalled <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign ready   = flags_q.resident && !flags_q.stalled && (busy_q == '0);
    assign stalled = flags_q.stalled;

endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
    parameter int unsigned NW  = 48,
    localparam int unsigned WW = $clog2(NW)
) (
    input  logic [NW-1:0] req,
    input  logic [WW-1:0] start,
    output logic          found,
    output logic [WW-1:0] idx
);

    // scan downward so that the nearest hit to start is written last
    always_comb begin
        int          pos;
        logic [WW-1:0] pw;
        found = 1'b0;
        idx   = '0;
        pos   = 0;
        pw    = '0;
        for (int k = NW - 1; k >= 0; k--) begin
            pos = int'(start) + k;
            if (pos >= int'(NW)) pos = pos - int'(NW);
            pw = WW'(pos);
            if (req[pw]) begin
                found = 1'b1;
                idx   = pw;
            end
        end
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import ws_pkg::*;
#(
    parameter int unsigned NUM_WARPS   = WS_NUM_WARPS,
    parameter int unsigned BUSY_CYCLES = WS_BUSY_CYCLES,
    localparam int unsigned WID_W      = $clog2(NUM_WARPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_vld,
    input  logic [WID_W-1:0] launch_wid,
    input  logic             mem_done_vld,
    input  logic [WID_W-1:0] mem_done_wid,
    output logic             iss0_vld,
    output logic [WID_W-1:0] iss0_wid,
    input  logic             iss0_acc,
    input  logic             iss0_mem,
    input  logic             iss0_exit,
    output logic             iss1_vld,
    output logic [WID_W-1:0] iss1_wid,
    input  logic             iss1_acc,
    input  logic             iss1_mem,
    input  logic             iss1_exit
);

    function automatic logic [WID_W-1:0] wrap_inc(input logic [WID_W-1:0] w);
        return (int'(w) >= int'(NUM_WARPS) - 1) ? '0 : w + 1'b1;
    endfunction

    logic [NUM_WARPS-1:0] ready_vec;
    logic [NUM_WARPS-1:0] stall_vec;
    logic [NUM_WARPS-1:0] ready_rest;
    logic [WID_W-1:0]     ptr_q;
    logic [WID_W-1:0]     start1;
    logic                 found0, found1;
    logic [WID_W-1:0]     pick0, pick1;
    logic                 take0, take1;
    ws_act_e              act0, act1;

    // first pick from the rotating pointer
    ws_rr_pick #(.NW(NUM_WARPS)) u_pick0 (
        .req   (ready_vec),
        .start (ptr_q),
        .found (found0),
        .idx   (pick0)
    );

    // second pick starts after the first and excludes it
    assign ready_rest = ready_vec & ~(NUM_WARPS'(1) << pick0);
    assign start1     = wrap_inc(pick0);

    ws_rr_pick #(.NW(NUM_WARPS)) u_pick1 (
        .req   (ready_rest),
        .start (start1),
        .found (found1),
        .idx   (pick1)
    );

    assign iss0_vld = found0;
    assign iss0_wid = pick0;
    assign iss1_vld = found0 && found1;
    assign iss1_wid = pick1;

    assign take0 = iss0_vld && iss0_acc;
    assign take1 = iss1_vld && iss1_acc;
    assign act0  = ws_decode_act(take0, iss0_mem, iss0_exit);
    assign act1  = ws_decode_act(take1, iss1_mem, iss1_exit);

    for (genvar i = 0; i < NUM_WARPS; i++) begin : g_slot
        ws_act_e slot_act;
        logic    hit0, hit1;

        assign hit0 = take0 && (iss0_wid == WID_W'(i));
        assign hit1 = take1 && (iss1_wid == WID_W'(i));

        always_comb begin
            if (hit0)      slot_act = act0;
            else if (hit1) slot_act = act1;
            else           slot_act = ACT_NONE;
        end

        ws_slot #(.BUSY(BUSY_CYCLES)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .launch_hit (launch_vld && (launch_wid == WID_W'(i))),
            .wake       (mem_done_vld && (mem_done_wid == WID_W'(i))),
            .act        (slot_act),
            .ready      (ready_vec[i]),
            .stalled    (stall_vec[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (take1) begin
            ptr_q <= wrap_inc(iss1_wid);
        end else if (take0) begin
            ptr_q <= wrap_inc(iss0_wid);
        end
    end

endmodule

// File: rtl/ws_sched_chk.sv
module ws_sched_chk #(
    parameter int unsigned NW  = 48,
    localparam int unsigned WW = $clog2(NW)
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_done_vld,
    input logic [WW-1:0] mem_done_wid,
    input logic          iss0_vld,
    input logic [WW-1:0] iss0_wid,
    input logic          iss0_acc,
    input logic          iss1_vld,
    input logic [WW-1:0] iss1_wid,
    input logic [NW-1:0] ready_vec,
    input logic [NW-1:0] stall_vec
);

    AST_PORTS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (iss0_vld && iss1_vld) |-> (iss0_wid != iss1_wid)); // R3

    AST_P1_NEEDS_P0: assert property (@(posedge clk) disable iff (rst)
        iss1_vld |-> iss0_vld); // R5

    AST_IDLE_ONLY_WHEN_NONE: assert property (@(posedge clk) disable iff (rst)
        !iss0_vld |-> (ready_vec == '0)); // R5

    AST_OFFER_IS_READY: assert property (@(posedge clk) disable iff (rst)
        iss0_vld |-> ready_vec[iss0_wid]); // R6

    AST_OFFER1_IS_READY: assert property (@(posedge clk) disable iff (rst)
        iss1_vld |-> ready_vec[iss1_wid]); // R6

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (iss0_vld && iss0_acc) |=>
            (!(iss0_vld && iss0_wid == $past(iss0_wid)) &&
             !(iss1_vld && iss1_wid == $past(iss0_wid)))); // R4

    AST_PARKED_NOT_OFFERED: assert property (@(posedge clk) disable iff (rst)
        iss0_vld |-> !stall_vec[iss0_wid]); // R7

    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mem_done_vld && (int'(mem_done_wid) < int'(NW))) |=>
            !stall_vec[$past(mem_done_wid)]); // R7

endmodule

bind warp_issue_sched ws_sched_chk #(.NW(NUM_WARPS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_done_vld (mem_done_vld),
    .mem_done_wid (mem_done_wid),
    .iss0_vld     (iss0_vld),
    .iss0_wid     (iss0_wid),
    .iss0_acc     (iss0_acc),
    .iss1_vld     (iss1_vld),
    .iss1_wid     (iss1_wid),
    .ready_vec    (ready_vec),
    .stall_vec    (stall_vec)
);

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       launch_vld = 1'b0;
    logic [5:0] launch_wid = '0;
    logic       mem_done_vld = 1'b0;
    logic [5:0] mem_done_wid = '0;
    logic       iss0_vld, iss1_vld;
    logic [5:0] iss0_wid, iss1_wid;
    logic       iss0_acc = 1'b0, iss0_mem = 1'b0, iss0_exit = 1'b0;
    logic       iss1_acc = 1'b0, iss1_mem = 1'b0, iss1_exit = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    warp_issue_sched u0 (
        .clk(clk), .rst(rst),
        .launch_vld(launch_vld), .launch_wid(launch_wid),
        .mem_done_vld(mem_done_vld), .mem_done_wid(mem_done_wid),
        .iss0_vld(iss0_vld), .iss0_wid(iss0_wid),
        .iss0_acc(iss0_acc), .iss0_mem(iss0_mem), .iss0_exit(iss0_exit),
        .iss1_vld(iss1_vld), .iss1_wid(iss1_wid),
        .iss1_acc(iss1_acc), .iss1_mem(iss1_mem), .iss1_exit(iss1_exit)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        launch_vld = 1'b0; mem_done_vld = 1'b0;
        iss0_acc = 1'b0; iss0_mem = 1'b0; iss0_exit = 1'b0;
        iss1_acc = 1'b0; iss1_mem = 1'b0; iss1_exit = 1'b0;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected port state; a wid of -1 means the port must be idle
    task automatic chk_ports(input string req, input int e0, input int e1);
        chk(iss0_vld == (e0 >= 0), req, "iss0_vld", int'(iss0_vld), int'(e0 >= 0));
        if (e0 >= 0) chk(int'(iss0_wid) == e0, req, "iss0_wid", int'(iss0_wid), e0);
        chk(iss1_vld == (e1 >= 0), req, "iss1_vld", int'(iss1_vld), int'(e1 >= 0));
        if (e1 >= 0) chk(int'(iss1_wid) == e1, req, "iss1_wid", int'(iss1_wid), e1);
    endtask

    task automatic do_reset();
        quiet();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic launch(input int w);
        launch_vld = 1'b1;
        launch_wid = 6'(w);
        tick();
        launch_vld = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk_ports("R1", -1, -1);
        launch(4);
        chk_ports("R2", 4, -1);
        do_reset();
        chk_ports("R1", -1, -1);
    endtask

    task automatic t_single_offer();
        do_reset();
        launch(5);
        chk_ports("R5", 5, -1);
        tick();
        chk_ports("R10", 5, -1);
    endtask

    task automatic t_pair_and_busy();
        do_reset();
        launch(3);
        launch(40);
        launch(20);
        chk_ports("R9", 3, 20);
        iss0_acc = 1'b1; iss1_acc = 1'b1;
        tick();
        quiet();
        chk_ports("R9", 40, -1);          // pointer now 21
        iss0_acc = 1'b1;
        tick();
        quiet();
        chk_ports("R4", -1, -1);          // 3 and 20 in cycle t+2
        tick();
        chk_ports("R4", -1, -1);          // cycle t+3
        tick();
        chk_ports("R4", 3, 20);           // cycle t+4, pointer 41 wraps
    endtask

    task automatic t_mem_park();
        do_reset();
        launch(7);
        chk_ports("R2", 7, -1);
        iss0_acc = 1'b1; iss0_mem = 1'b1;
        tick();
        quiet();
        for (int k = 0; k < 5; k++) begin
            tick();
            chk_ports("R7", -1, -1);
        end
        launch(7);                        // occupied: must not clear the park
        chk_ports("R2", -1, -1);
        mem_done_vld = 1'b1; mem_done_wid = 6'd7;
        tick();
        quiet();
        chk_ports("R7", 7, -1);
    endtask

    task automatic t_exit_and_relaunch();
        do_reset();
        launch(12);
        launch(30);
        chk_ports("R9", 12, 30);
        iss0_acc = 1'b1; iss0_exit = 1'b1; iss1_acc = 1'b1;
        tick();
        quiet();
        for (int k = 0; k < 3; k++) begin
            chk_ports("R8", -1, -1);
            tick();
        end
        chk_ports("R8", 30, -1);
        launch(12);
        chk_ports("R8", 12, 30);          // pointer 31 wraps to 12
    endtask

    task automatic t_port1_only();
        do_reset();
        launch(1);
        launch(2);
        chk_ports("R3", 1, 2);
        iss1_acc = 1'b1;
        tick();
        quiet();
        chk_ports("R10", 1, -1);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single_offer();
        t_pair_and_busy();
        t_mem_park();
        t_exit_and_relaunch();
        t_port1_only();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule